// File: doc/BRIEF.md
# Serial Flash Raw Shift Engine

This block runs short, raw serial transactions against a serial flash device over a single-data-line SPI master port. Software uses a simple byte-wide register bus to do three things. It fills up to six transmit byte slots. It writes a transfer length expressed in bits. It then sets a start bit. The engine asserts chip select and shifts the bytes out most significant bit first, while capturing the same number of bytes from the device. When it is done it releases chip select and clears the start bit by itself.

The opcode, address, dummy and data bytes of a transaction all share the six slots. Transmit slots are consumed from the highest index downward. Received bytes land in the receive slots in mirrored order, so the last byte received always sits in receive slot 0. The serial clock idles low. Data is launched on the falling edge and sampled on the rising edge (SPI mode 0). The serial clock period is `2*SCK_HALF` system clock cycles.

Top module: `sfl_shift_engine`

## Requirements
- R1: After reset, chip select (`spi_cs_n`) is high and `spi_sck` is low. The control register (0x00), the bit-count register (0x04), every transmit slot and every receive slot all read 0x00.
- R2: A write to the control register (0x00) with data bit 2 set starts a transaction. Bit 2 of the control register then reads 1 from the next cycle until the transaction has ended, and reads 0 after that.
- R3: Transmit slot i sits at address 0x20+4*i and receive slot i at address 0x40+4*i. Bits leave MSB first. The first byte comes from transmit slot 5, then slot 4, and so on downward. A slot never written since reset sends 0x00.
- R4: The bit-count register (0x04) holds the transfer length in bits, and a transaction produces exactly that many rising `spi_sck` edges. A count of zero completes within two cycles and never lowers chip select.
- R5: After an n-byte transaction, the byte received in position k (0 = first) reads from receive slot n-1-k. Receive slots n and above read 0x00.
- R6: Mode 0 timing applies: `spi_sck` stays low whenever chip select is high, and `spi_mosi` does not change while `spi_sck` stays high.
- R7: Chip select stays low for the whole transaction. It rises exactly `2*SCK_HALF` cycles after the last falling `spi_sck` edge. The busy bit clears one cycle after chip select rises.
- R8: While a transaction is in progress, writes to the transmit slots, the bit-count register and the control register are ignored.
- R9: Transmit slot and bit-count contents persist across transactions until software rewrites them.
- R10: A bit count above 48 is treated as 48. A count that is not a multiple of 8 is rounded down to the next multiple of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The busy bit is set on the clock edge that takes the start write and is read back in the very next cycle. The first rising `spi_sck` edge follows `SCK_HALF` cycles after chip select falls. Chip select rises exactly `2*SCK_HALF` cycles after the last falling edge, which the bench measures as a time difference between the two port edges. The bench's flash model changes `spi_miso` only on falling `spi_sck` edges and captures `spi_mosi` only on rising ones, so neither side races the design. Slot contents and the busy bit are read combinationally, only after polling has seen the busy bit clear, which is one cycle after chip select rises.

// File: rtl/sfl_pkg.sv
// Shared constants and types of the serial flash raw shift engine.
// Assumes an 8-bit register bus with byte addresses.
package sfl_pkg;
    localparam int DATA_W = 8;
    localparam logic [7:0] A_CTRL    = 8'h00;
    localparam logic [7:0] A_BITCNT  = 8'h04;
    localparam logic [7:0] A_TX_BASE = 8'h20;
    localparam logic [7:0] A_RX_BASE = 8'h40;
    localparam int GO_BIT = 2;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SHIFT,
        SQ_TAIL,
        SQ_DONE
    } seq_state_t;

    // Byte address of slot idx inside a slot window starting at base.
    function automatic logic [7:0] slot_addr(logic [7:0] base, int idx);
        return base + 8'(4 * idx);
    endfunction
endpackage

// File: rtl/sfl_regs.sv
// Register file: transmit slots, bit count, start decode and read mux.
// Assumes single-cycle writes. All writes are dropped while busy is high.
module sfl_regs
    import sfl_pkg::*;
#(
    parameter int NUM_SLOTS = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr,
    input  logic [7:0]                         addr,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic                               busy,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]   rx_bytes,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]   tx_bytes,
    output logic [DATA_W-1:0]                  bitcnt,
    output logic                               launch,
    output logic [DATA_W-1:0]                  rdata
);
    logic wr_ok;

    // Writes are accepted only while no transaction runs.
    assign wr_ok  = wr && !busy;
    // Start request: write of the go bit into the control register.
    assign launch = wr_ok && (addr == A_CTRL) && wdata[GO_BIT];

    // Transfer length register, in bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bitcnt <= '0;
        else if (wr_ok && addr == A_BITCNT)
            bitcnt <= wdata;
    end

    // One register per transmit slot, decoded at its own address.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_tx
        localparam logic [7:0] MY_ADDR = slot_addr(A_TX_BASE, i);
        always_ff @(posedge clk) begin
            if (!rst_n)
                tx_bytes[i] <= '0;
            else if (wr_ok && addr == MY_ADDR)
                tx_bytes[i] <= wdata;
        end
    end

    // Combinational readback of the addressed register.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)
            rdata[GO_BIT] = busy;
        else if (addr == A_BITCNT)
            rdata = bitcnt;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (addr == slot_addr(A_TX_BASE, i))
                rdata = tx_bytes[i];
            if (addr == slot_addr(A_RX_BASE, i))
                rdata = rx_bytes[i];
        end
    end
endmodule

// File: rtl/sfl_seq.sv
// Transaction sequencer: serial clock divider, chip select and bit counter.
// Assumes SCK_HALF >= 1. A request is clamped to MAX_BITS and rounded down
// to whole bytes. Emits a sample strobe on each rising serial clock edge and
// a shift strobe on each falling edge except the last one.
module sfl_seq
    import sfl_pkg::*;
#(
    parameter int SCK_HALF = 2,
    parameter int MAX_BITS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DATA_W-1:0] nbits_req,
    output logic              busy,
    output logic              sck,
    output logic              cs_n,
    output logic              sample_en,
    output logic              shift_en
);
    localparam int DIV_W = (2 * SCK_HALF > 1) ? $clog2(2 * SCK_HALF) : 1;
    localparam int CNT_W = $clog2(MAX_BITS + 1);
    localparam logic [DATA_W-1:0] MAX_REQ  = DATA_W'(MAX_BITS);
    localparam logic [DIV_W-1:0]  HALF_END = DIV_W'(SCK_HALF - 1);
    localparam logic [DIV_W-1:0]  TAIL_END = DIV_W'(2 * SCK_HALF - 1);

    seq_state_t       state;
    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] bits_left;
    logic [CNT_W-1:0] nbits_eff;
    logic             edge_tick;

    // Clamp the request to the slot capacity and drop any partial byte.
    always_comb begin
        if (nbits_req >= MAX_REQ)
            nbits_eff = CNT_W'(MAX_BITS);
        else
            nbits_eff = CNT_W'(nbits_req) & ~CNT_W'(7);
    end

    // Half-period boundary inside the shift phase.
    assign edge_tick = (state == SQ_SHIFT) && (div_cnt == HALF_END);
    assign sample_en = edge_tick && !sck;
    assign shift_en  = edge_tick && sck && (bits_left != CNT_W'(1));
    assign busy      = (state != SQ_IDLE);

    // Main state machine: idle, shift, chip-select tail, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            sck       <= 1'b0;
            cs_n      <= 1'b1;
            div_cnt   <= '0;
            bits_left <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (launch) begin
                        div_cnt   <= '0;
                        sck       <= 1'b0;
                        bits_left <= nbits_eff;
                        if (nbits_eff == '0) begin
                            state <= SQ_DONE;
                        end else begin
                            state <= SQ_SHIFT;
                            cs_n  <= 1'b0;
                        end
                    end
                end
                SQ_SHIFT: begin
                    if (div_cnt == HALF_END) begin
                        div_cnt <= '0;
                        sck     <= !sck;
                        if (sck) begin
                            bits_left <= bits_left - CNT_W'(1);
                            if (bits_left == CNT_W'(1))
                                state <= SQ_TAIL;
                        end
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
                SQ_TAIL: begin
                    if (div_cnt == TAIL_END) begin
                        div_cnt <= '0;
                        cs_n    <= 1'b1;
                        state   <= SQ_DONE;
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
                default: begin
                    state <= SQ_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sfl_shifter.sv
// Data path: a transmit shift register loaded from the slots (top slot
// first) and a receive shift register that fills from the bottom, so the
// last received byte ends in slot 0. Assumes the strobes come from sfl_seq.
module sfl_shifter
    import sfl_pkg::*;
#(
    parameter int NUM_SLOTS = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic                              shift,
    input  logic                              sample,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  tx_bytes,
    input  logic                              miso,
    output logic                              mosi,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  rx_bytes
);
    localparam int W = NUM_SLOTS * DATA_W;

    logic [W-1:0] tx_sr;
    logic [W-1:0] rx_sr;

    // Transmit register: load all slots, then move one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sr <= '0;
        else if (load)
            tx_sr <= tx_bytes;
        else if (shift)
            tx_sr <= {tx_sr[W-2:0], 1'b0};
    end

    // Receive register: clear at start, take one bit per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sr <= '0;
        else if (load)
            rx_sr <= '0;
        else if (sample)
            rx_sr <= {rx_sr[W-2:0], miso};
    end

    assign mosi     = tx_sr[W-1];
    assign rx_bytes = rx_sr;
endmodule

// File: rtl/sfl_shift_engine.sv
// Top of the serial flash raw shift engine. Connects the register file, the
// sequencer and the data path. Assumes one flash device on one chip select.
module sfl_shift_engine
    import sfl_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter int SCK_HALF  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_sck,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int MAX_BITS = NUM_SLOTS * DATA_W;

    logic [NUM_SLOTS-1:0][DATA_W-1:0] tx_bytes;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] rx_bytes;
    logic [DATA_W-1:0]                bitcnt;
    logic                             launch;
    logic                             busy;
    logic                             sample_en;
    logic                             shift_en;

    sfl_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (busy),
        .rx_bytes (rx_bytes),
        .tx_bytes (tx_bytes),
        .bitcnt   (bitcnt),
        .launch   (launch),
        .rdata    (reg_rdata)
    );

    sfl_seq #(.SCK_HALF(SCK_HALF), .MAX_BITS(MAX_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .nbits_req (bitcnt),
        .busy      (busy),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .sample_en (sample_en),
        .shift_en  (shift_en)
    );

    sfl_shifter #(.NUM_SLOTS(NUM_SLOTS)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .shift    (shift_en),
        .sample   (sample_en),
        .tx_bytes (tx_bytes),
        .miso     (spi_miso),
        .mosi     (spi_mosi),
        .rx_bytes (rx_bytes)
    );
endmodule

// File: rtl/sfl_shift_engine_chk.sv
// Protocol checker for sfl_shift_engine, attached through bind.
// Assumes a synchronous active-low reset held for at least one edge.
module sfl_shift_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi,
    input logic busy
);
    // R6: the serial clock never leaves idle without chip select.
    p_sck_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R6: data is held for the whole high phase of the serial clock.
    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R7: chip select is low only inside a busy transaction.
    p_cs_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R7: busy ends only after chip select has been high for a cycle.
    p_busy_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (spi_cs_n && $past(spi_cs_n)));

    // R2: a chip select fall belongs to a started transaction.
    p_cs_fall_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> busy);
endmodule

bind sfl_shift_engine sfl_shift_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .busy     (busy)
);

// File: tb/sfl_shift_engine_test.sv
`timescale 1ns/1ps
module sfl_shift_engine_test;
    localparam int SCK_HALF = 2;
    localparam int NVEC = 6;
    // Each vector: {byte count[7:0], tx slots 5..0 [47:0], flash reply [47:0]}
    localparam logic [103:0] VEC [NVEC] = '{
        {8'd6, 48'hA1B2C3D4E5F6, 48'h0F1E2D3C4B5A},
        {8'd1, 48'h3C1122334455, 48'hC3FFFFFFFFFF},
        {8'd3, 48'h9F0102030405, 48'h00EF4017AAAA},
        {8'd4, 48'h0B00123400AA, 48'h80018002FFFF},
        {8'd2, 48'hFF00FF00FF00, 48'h5555AAAA0000},
        {8'd5, 48'h0123456789AB, 48'hFEDCBA987654}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  reported = 0;

    // Flash model state.
    logic [47:0] miso_pat = '0;
    logic [47:0] miso_sr  = '0;
    logic [47:0] mosi_cap = '0;
    int          sck_rises = 0;
    int          cs_falls = 0;
    realtime     t_fall = 0.0;
    realtime     t_rise = 0.0;

    always #2.5 clk = ~clk;

    sfl_shift_engine #(.NUM_SLOTS(6), .SCK_HALF(SCK_HALF)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Flash model: reply shifts on falling edges, capture on rising edges.
    always @(negedge spi_cs_n) begin
        miso_sr   = miso_pat;
        spi_miso  = miso_sr[47];
        mosi_cap  = '0;
        sck_rises = 0;
        cs_falls++;
    end
    always @(negedge spi_sck) begin
        t_fall = $realtime;
        if (!spi_cs_n) begin
            miso_sr  = miso_sr << 1;
            spi_miso = miso_sr[47];
        end
    end
    always @(posedge spi_sck) begin
        mosi_cap = {mosi_cap[46:0], spi_mosi};
        sck_rises++;
    end
    always @(posedge spi_cs_n) t_rise = $realtime;

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [7:0] v;
        ok = 0;
        for (int i = 0; i < 2000; i++) begin
            rd(8'h00, v);
            if (v[2] == 1'b0) begin
                ok = 1;
                break;
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [7:0]  v;
        bit          ok;
        logic [47:0] tx, rp, exp_bits;
        int          nb, falls0;

        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state at the ports and in every register.
        check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 pins", {spi_cs_n, spi_sck}, 2'b10);
        rd(8'h00, v); check(v === 8'h00, "R1 ctrl", v, 0);
        rd(8'h04, v); check(v === 8'h00, "R1 bitcnt", v, 0);
        for (int i = 0; i < 6; i++) begin
            rd(8'h20 + 8'(4 * i), v); check(v === 8'h00, "R1 tx slot", v, 0);
            rd(8'h40 + 8'(4 * i), v); check(v === 8'h00, "R1 rx slot", v, 0);
        end

        // R3: unwritten slot 4 supplies 0x00 after slot 5.
        wr(8'h34, 8'hA5);
        wr(8'h04, 8'd16);
        miso_pat = 48'h1234_0000_0000;
        wr(8'h00, 8'h04);
        wait_idle(ok);
        check(ok, "R2 done", ok, 1);
        check(mosi_cap[15:0] === 16'hA500, "R3 unwritten slot", mosi_cap[15:0], 16'hA500);

        // Table of vectors walked by one loop.
        for (int e = 0; e < NVEC; e++) begin
            nb = int'(VEC[e][103:96]);
            tx = VEC[e][95:48];
            rp = VEC[e][47:0];
            for (int i = 0; i < 6; i++) wr(8'h20 + 8'(4 * i), tx[8*i +: 8]);
            wr(8'h04, 8'(nb * 8));
            miso_pat = rp;
            wr(8'h00, 8'h04);
            rd(8'h00, v);
            check(v[2] === 1'b1, "R2 busy set", v, 8'h04);
            wait_idle(ok);
            check(ok, "R2 busy cleared", ok, 1);
            check(sck_rises == nb * 8, "R4 edge count", sck_rises, nb * 8);
            exp_bits = tx >> (48 - 8 * nb);
            check(mosi_cap === exp_bits, "R3 mosi order", mosi_cap, exp_bits);
            check(int'((t_rise - t_fall) * 1000) == 2 * SCK_HALF * 5000,
                  "R7 cs tail", int'((t_rise - t_fall) * 1000), 2 * SCK_HALF * 5000);
            for (int j = 0; j < 6; j++) begin
                logic [7:0] ex;
                ex = (j < nb) ? rp[47 - 8 * (nb - 1 - j) -: 8] : 8'h00;
                rd(8'h40 + 8'(4 * j), v);
                check(v === ex, "R5 rx slot", v, ex);
            end
        end

        // R9: slots and bit count keep the last written values.
        tx = VEC[NVEC-1][95:48];
        for (int i = 0; i < 6; i++) begin
            rd(8'h20 + 8'(4 * i), v);
            check(v === tx[8*i +: 8], "R9 tx slot persists", v, tx[8*i +: 8]);
        end
        rd(8'h04, v); check(v === 8'd40, "R9 bitcnt persists", v, 8'd40);

        // R4: zero length completes without chip select activity.
        falls0 = cs_falls;
        wr(8'h04, 8'd0);
        wr(8'h00, 8'h04);
        rd(8'h00, v);
        check(v[2] === 1'b0, "R4 zero length idle", v, 0);
        check(cs_falls == falls0, "R4 zero length no cs", cs_falls, falls0);

        // R10: clamp above capacity and round down partial bytes.
        wr(8'h04, 8'd60); wr(8'h00, 8'h04); wait_idle(ok);
        check(sck_rises == 48, "R10 clamp", sck_rises, 48);
        wr(8'h04, 8'd12); wr(8'h00, 8'h04); wait_idle(ok);
        check(sck_rises == 8, "R10 round down", sck_rises, 8);

        // R8: writes during a transaction are ignored.
        wr(8'h34, 8'h5C); wr(8'h30, 8'h3A); wr(8'h04, 8'd16);
        falls0 = cs_falls;
        wr(8'h00, 8'h04);
        wr(8'h34, 8'hEE);
        wr(8'h04, 8'd8);
        wr(8'h00, 8'h04);
        wait_idle(ok);
        repeat (4 * SCK_HALF + 4) @(negedge clk);
        check(cs_falls == falls0 + 1, "R8 no restart", cs_falls, falls0 + 1);
        check(mosi_cap[15:0] === 16'h5C3A, "R8 data kept", mosi_cap[15:0], 16'h5C3A);
        rd(8'h34, v); check(v === 8'h5C, "R8 slot write ignored", v, 8'h5C);
        rd(8'h04, v); check(v === 8'd16, "R8 bitcnt write ignored", v, 8'd16);

        report();
        $finish;
    end
endmodule